// File: doc/BRIEF.md
# Prefix and Halt Step Controller

This block sequences the instruction steps of a small 16-bit CPU core that uses segmented addresses. In each step the core either sits halted, spending one wait cycle and fetching nothing, or it requests one opcode byte, spends one wait cycle, and then hands the byte to the execute unit together with any pending prefix state. Segment-override and repeat prefix bytes are absorbed by the controller and are not dispatched. Their effect is attached to the next non-prefix instruction and then dropped.

The execute unit reports completion with `exec_done` and asks for the halted state with `halt_set` when it finishes an opcode that is flagged as a halt. An interrupt entry sequence leaves the halted state by pulsing `halt_clear`. The controller also holds the architectural reset values of the code segment, the data segment, the instruction pointer and the flags word. The instruction pointer advances by one for every opcode byte accepted.

Top module: `prefix_halt_stepper`

## Requirements
- R1: After reset, `arch_cs` is 0xFFFF, `arch_ds` is 0x0000, `arch_ip` is 0x0000, `arch_flags` is 0x8000, `halted` is 0, `fetch_req` is 1 and no prefix is pending.
- R2: A running step holds `fetch_req` high until `fetch_valid` is seen. It then spends exactly one cycle with `wait_cyc` high and no fetch, and then dispatches. During a fetch stall there is no wait cycle and no dispatch.
- R3: `arch_ip` increases by one for each accepted opcode byte and is unchanged otherwise.
- R4: Opcodes 0x26, 0x2E, 0x36 and 0x3E set a pending segment override. It is presented as `disp_seg_valid`=1 with `disp_seg` equal to 0 (ES), 1 (CS), 2 (SS) or 3 (DS), which is opcode bits [4:3].
- R5: Opcode 0xF2 sets a pending repeat with `disp_rep_zero`=0 (repeat while not zero). Opcode 0xF3 sets one with `disp_rep_zero`=1 (repeat while zero). Either one shows `disp_rep_valid`=1.
- R6: A prefix byte is never dispatched (`disp_valid` stays 0 in its step). Its effect reaches only the next non-prefix instruction, and both latches are cleared once that instruction completes.
- R7: Consecutive prefixes accumulate. A later segment prefix replaces an earlier one, and a repeat prefix and a segment prefix can be pending together.
- R8: `disp_halt_op` is 1 exactly when the dispatched opcode is 0xF4. Completion with `halt_set` high enters the halted state.
- R9: While halted, every cycle has `wait_cyc`=1 and `fetch_req`=0. On `halt_clear` the next cycle requests a fetch.
- R10: `halt_clear` while not halted has no effect on the step sequence or on `halted`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | output | 1 | Opcode byte requested |
| fetch_valid | input | 1 | Requested byte is present on `fetch_byte` |
| fetch_byte | input | 8 | Fetched opcode byte |
| wait_cyc | output | 1 | Current cycle is a wait cycle |
| disp_valid | output | 1 | Non-prefix opcode offered to the execute unit |
| disp_opcode | output | 8 | Dispatched opcode |
| disp_halt_op | output | 1 | Dispatched opcode is the halt opcode |
| disp_seg_valid | output | 1 | Segment override pending |
| disp_seg | output | 2 | Override index: 0 ES, 1 CS, 2 SS, 3 DS |
| disp_rep_valid | output | 1 | Repeat prefix pending |
| disp_rep_zero | output | 1 | Repeat condition: 1 while zero, 0 while not zero |
| exec_done | input | 1 | Execute unit finished the dispatched opcode |
| halt_set | input | 1 | With `exec_done`, enter the halted state |
| halt_clear | input | 1 | Interrupt entry: leave the halted state |
| halted | output | 1 | Core is halted |
| arch_cs | output | 16 | Code segment register |
| arch_ds | output | 16 | Data segment register |
| arch_ip | output | 16 | Instruction pointer |
| arch_flags | output | 16 | Flags word |

## Verification
A stream of opcode bytes is fed through the table. It mixes plain opcodes, single prefixes, runs of two and three prefixes, and a plain opcode right after a prefixed one. This separates a prefix that sticks for one instruction from one that sticks longer, and a replaced segment override from one that is merged or lost. A held-off fetch shows that the wait cycle and the dispatch wait for a valid byte. A repeat prefix placed before the halt opcode shows that halting clears the latches. Halt-clear pulses sent while running and while halted separate an ignored wake-up from a real one. A reset in the middle of the stream, with a prefix already pending, shows that reset drops the prefix.

// File: rtl/prefix_halt_stepper.sv
module prefix_halt_stepper #(
  parameter int WORD_W = 16,
  parameter int OP_W = 8,
  parameter logic [WORD_W-1:0] CS_AT_RESET = 16'hFFFF,
  parameter logic [WORD_W-1:0] FLAGS_AT_RESET = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              fetch_req,
  input  logic              fetch_valid,
  input  logic [OP_W-1:0]   fetch_byte,
  output logic              wait_cyc,
  output logic              disp_valid,
  output logic [OP_W-1:0]   disp_opcode,
  output logic              disp_halt_op,
  output logic              disp_seg_valid,
  output logic [1:0]        disp_seg,
  output logic              disp_rep_valid,
  output logic              disp_rep_zero,
  input  logic              exec_done,
  input  logic              halt_set,
  input  logic              halt_clear,
  output logic              halted,
  output logic [WORD_W-1:0] arch_cs,
  output logic [WORD_W-1:0] arch_ds,
  output logic [WORD_W-1:0] arch_ip,
  output logic [WORD_W-1:0] arch_flags
);

  typedef enum logic [1:0] {ST_FETCH, ST_WAIT, ST_DISP, ST_HALT} step_t;

  step_t             state;
  logic [OP_W-1:0]   op_q;
  logic              seg_v, rep_v, rep_z;
  logic [1:0]        seg_q;
  logic [WORD_W-1:0] ip_q, cs_q, ds_q, flags_q;

  wire is_seg  = (op_q[7:5] == 3'b001) && (op_q[2:0] == 3'b110);
  wire is_rep  = (op_q[7:1] == 7'b1111001);
  wire is_pfx  = is_seg || is_rep;
  wire in_disp = (state == ST_DISP);

  assign fetch_req      = (state == ST_FETCH);
  assign wait_cyc       = (state == ST_WAIT) || (state == ST_HALT);
  assign halted         = (state == ST_HALT);
  assign disp_valid     = in_disp && !is_pfx;
  assign disp_opcode    = op_q;
  assign disp_halt_op   = (op_q == 8'hF4);
  assign disp_seg_valid = seg_v;
  assign disp_seg       = seg_q;
  assign disp_rep_valid = rep_v;
  assign disp_rep_zero  = rep_z;
  assign arch_cs        = cs_q;
  assign arch_ds        = ds_q;
  assign arch_ip        = ip_q;
  assign arch_flags     = flags_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_FETCH;
      op_q    <= '0;
      seg_v   <= 1'b0;
      seg_q   <= '0;
      rep_v   <= 1'b0;
      rep_z   <= 1'b0;
      ip_q    <= '0;
      cs_q    <= CS_AT_RESET;
      ds_q    <= '0;
      flags_q <= FLAGS_AT_RESET;
    end else begin
      case (state)
        ST_FETCH: if (fetch_valid) begin
          op_q  <= fetch_byte;
          ip_q  <= ip_q + 1'b1;
          state <= ST_WAIT;
        end
        ST_WAIT: state <= ST_DISP;
        ST_DISP: begin
          if (is_pfx) begin
            if (is_seg) begin
              seg_v <= 1'b1;
              seg_q <= op_q[4:3];
            end
            if (is_rep) begin
              rep_v <= 1'b1;
              rep_z <= op_q[0];
            end
            state <= ST_FETCH;
          end else if (exec_done) begin
            seg_v <= 1'b0;
            rep_v <= 1'b0;
            state <= halt_set ? ST_HALT : ST_FETCH;
          end
        end
        ST_HALT: if (halt_clear) state <= ST_FETCH;
        default: state <= ST_FETCH;
      endcase
    end
  end

  assert_fetch_wait_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fetch_req, wait_cyc, disp_valid}));

  assert_disp_after_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disp_valid) |-> $past(wait_cyc));

  assert_ip_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_req && fetch_valid) |=> $stable(arch_ip));

  assert_seg_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_disp && is_seg) |=> (seg_v && seg_q == $past(op_q[4:3])));

  assert_rep_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_disp && is_rep) |=> (rep_v && rep_z == $past(op_q[0])));

  assert_clear_after_insn_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && exec_done) |=> (!seg_v && !rep_v));

  assert_rep_kept_by_seg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_disp && is_seg) |=> ($stable(rep_v) && $stable(rep_z)));

  assert_halted_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!fetch_req && wait_cyc && !disp_valid));

  assert_clear_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && !(disp_valid && exec_done && halt_set)) |=> !halted);

endmodule

// File: tb/prefix_halt_stepper_test.sv
`timescale 1ns/1ps
module prefix_halt_stepper_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_req, fetch_valid = 1'b0;
  logic [7:0]  fetch_byte = 8'h00;
  logic        wait_cyc, disp_valid, disp_halt_op;
  logic [7:0]  disp_opcode;
  logic        disp_seg_valid, disp_rep_valid, disp_rep_zero;
  logic [1:0]  disp_seg;
  logic        exec_done, halt_set, halt_clear = 1'b0, halted;
  logic [15:0] arch_cs, arch_ds, arch_ip, arch_flags;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  assign exec_done = disp_valid;
  assign halt_set  = disp_valid & disp_halt_op;

  prefix_halt_stepper uut (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_valid(fetch_valid),
    .fetch_byte(fetch_byte), .wait_cyc(wait_cyc), .disp_valid(disp_valid),
    .disp_opcode(disp_opcode), .disp_halt_op(disp_halt_op),
    .disp_seg_valid(disp_seg_valid), .disp_seg(disp_seg),
    .disp_rep_valid(disp_rep_valid), .disp_rep_zero(disp_rep_zero),
    .exec_done(exec_done), .halt_set(halt_set), .halt_clear(halt_clear),
    .halted(halted), .arch_cs(arch_cs), .arch_ds(arch_ds), .arch_ip(arch_ip),
    .arch_flags(arch_flags)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // row: [15:8] byte, [7] dispatched, [6] seg valid, [5:4] seg, [3] rep valid, [2] rep zero
  localparam int ROWS = 12;
  localparam logic [15:0] TABLE [ROWS] = '{
    {8'h90, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 2'b00},
    {8'h26, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'b00},
    {8'h90, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 2'b00},
    {8'h90, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 2'b00},
    {8'h2E, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'b00},
    {8'h36, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'b00},
    {8'hF3, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'b00},
    {8'hA4, 1'b1, 1'b1, 2'd2, 1'b1, 1'b1, 2'b00},
    {8'h3E, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'b00},
    {8'hF2, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'b00},
    {8'hA6, 1'b1, 1'b1, 2'd3, 1'b1, 1'b0, 2'b00},
    {8'h00, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 2'b00}
  };

  // called at a negedge where a fetch is expected; returns at the next such negedge
  task automatic feed(logic [15:0] row);
    chk("R2 fetch_req", fetch_req, 1'b1);
    fetch_valid = 1'b1;
    fetch_byte  = row[15:8];
    @(negedge clk);
    fetch_valid = 1'b0;
    chk("R2 wait_cyc", wait_cyc, 1'b1);
    chk("R2 no fetch in wait", fetch_req, 1'b0);
    @(negedge clk);
    if (row[7]) begin
      chk("R2 disp_valid", disp_valid, 1'b1);
      chk("R8 disp_opcode", disp_opcode, row[15:8]);
      chk("R8 disp_halt_op", disp_halt_op, row[15:8] == 8'hF4);
      chk("R4 seg_valid", disp_seg_valid, row[6]);
      if (row[6]) chk("R4 seg index", disp_seg, row[5:4]);
      chk("R5 rep_valid", disp_rep_valid, row[3]);
      if (row[3]) chk("R5 rep_zero", disp_rep_zero, row[2]);
    end else begin
      chk("R6 prefix not dispatched", disp_valid, 1'b0);
    end
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 cs", arch_cs, 16'hFFFF);
    chk("R1 ds", arch_ds, 16'h0000);
    chk("R1 ip", arch_ip, 16'h0000);
    chk("R1 flags", arch_flags, 16'h8000);
    chk("R1 halted", halted, 1'b0);
    chk("R1 fetch_req", fetch_req, 1'b1);
    chk("R1 no seg", disp_seg_valid, 1'b0);
    chk("R1 no rep", disp_rep_valid, 1'b0);

    for (int i = 0; i < ROWS; i++) feed(TABLE[i]);
    chk("R3 ip after stream", arch_ip, ROWS);

    // fetch stall
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R2 stall fetch_req", fetch_req, 1'b1);
      chk("R2 stall no wait", wait_cyc, 1'b0);
      chk("R2 stall no disp", disp_valid, 1'b0);
      chk("R3 stall ip", arch_ip, ROWS);
    end

    // wake-up while running: R10
    halt_clear = 1'b1;
    @(negedge clk);
    halt_clear = 1'b0;
    chk("R10 halted stays low", halted, 1'b0);
    chk("R10 still fetching", fetch_req, 1'b1);
    chk("R10 no wait", wait_cyc, 1'b0);
    feed({8'h90, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 2'b00});

    // halt behind a repeat prefix: R8 R9
    feed({8'h26, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'b00});
    feed({8'hF3, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'b00});
    feed({8'hF4, 1'b1, 1'b1, 2'd0, 1'b1, 1'b1, 2'b00});
    for (int i = 0; i < 4; i++) begin
      chk("R8 halted", halted, 1'b1);
      chk("R9 no fetch", fetch_req, 1'b0);
      chk("R9 wait each cycle", wait_cyc, 1'b1);
      chk("R6 latches cleared by halt op", {disp_seg_valid, disp_rep_valid}, 2'b00);
      @(negedge clk);
    end
    chk("R3 ip frozen while halted", arch_ip, ROWS + 4);
    halt_clear = 1'b1;
    @(negedge clk);
    halt_clear = 1'b0;
    chk("R9 woken", halted, 1'b0);
    chk("R9 fetch after wake", fetch_req, 1'b1);
    feed({8'h90, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 2'b00});

    // reset with a prefix pending: R1
    feed({8'h36, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'b00});
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 ip after reset", arch_ip, 16'h0000);
    chk("R1 seg dropped", disp_seg_valid, 1'b0);
    feed({8'h90, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 2'b00});
    chk("R3 ip after reset fetch", arch_ip, 16'h0001);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule